// File: doc/BRIEF.md
# Pad Deep-Sleep Output Controller

This block sits between the pad multiplexer and the pad ring. Each pad has a normal output value and output-enable from the functional logic. The block passes them straight through until the power manager signals deep-sleep entry. At that moment, every pad that software has armed moves into sleep. From then on the block drives that pad according to its programmed sleep behaviour. The behaviours are: force low, force high, release the pad, or hold whatever was driven at the moment of entry.

A pad stays in sleep after wake-up. It returns to normal routing only when software explicitly clears that pad's sleep status. Configuration goes through a small single-cycle register port, with a field selector and a pad index. Each pad has a lock bit. Once the lock bit is cleared, that pad's arm bit and behaviour cannot be changed until reset. A combinational read port returns any pad's field, and the status bits are also brought out as a vector.

Top module: `pad_sleep_ctrl`

## Requirements
- R1: After reset, every pad has sleep mode 2, arm bit 0, status 0 and lock 1, and every pad output and output-enable equals its normal input.
- R2: While a pad's status is 1, mode 0 drives output 0 with output-enable 1, and mode 1 drives output 1 with output-enable 1.
- R3: While a pad's status is 1, mode 2 drives output-enable 0 and output 0.
- R4: A clock edge with the sleep-entry input high sets the status of every pad whose arm bit is 1. The override is visible from that edge onward.
- R5: Status returns to 0 only on a status-field write whose data bit 0 is 0. A write with data bit 0 equal to 1 leaves status unchanged.
- R6: A lock-field write with data bit 0 equal to 0 clears that pad's lock. While the lock is 0, writes to the arm and mode fields of that pad are ignored. Writing 1 to the lock does not set it again.
- R7: A pad whose arm bit is 0 at sleep entry keeps normal routing.
- R8: Mode 3 drives the output and output-enable values that were on the normal inputs in the cycle the status was set.
- R9: A sleep entry while a pad's status is already 1 does not recapture the held values.
- R10: If a status clear and a sleep entry hit an armed pad in the same cycle, the entry wins and status stays 1.
- R11: The field selector encodes 0 = arm (data bit 0), 1 = mode (data bits 1:0), 2 = status, 3 = lock. The read port returns the selected field zero-extended to 2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| sleep_entry_i | input | 1 | Deep-sleep entry, sampled each rising edge |
| norm_out_i | input | NumPads | Normal per-pad output value |
| norm_oe_i | input | NumPads | Normal per-pad output-enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_field_i | input | 2 | Field selected by the write |
| wr_pad_i | input | IdxW | Pad index of the write |
| wr_data_i | input | 2 | Write data |
| rd_field_i | input | 2 | Field selected for readback |
| rd_pad_i | input | IdxW | Pad index for readback |
| rd_data_o | output | 2 | Readback data, combinational |
| pad_out_o | output | NumPads | Final pad output value |
| pad_oe_o | output | NumPads | Final pad output-enable |
| status_o | output | NumPads | Per-pad sleep status |

## Verification
The assertions assume three things about the inputs. Reset is held low from time zero until at least one clock edge. Writes and sleep-entry pulses are stable across the rising edge, and a write index at or above the pad count is never used. The stimulus always drives inputs on the falling edge and never goes outside the index range. It also holds the reset for three cycles before any write or entry pulse. The normal inputs are changed right after an entry pulse. This makes a hold-mode capture taken on the wrong cycle show up at the outputs.

// File: rtl/pss_pkg.sv
// Shared types for the pad deep-sleep controller.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package pss_pkg;

    // Sleep behaviour codes; the numeric values are software-visible.
    typedef enum logic [1:0] {
        SLP_LOW   = 2'd0,
        SLP_HIGH  = 2'd1,
        SLP_FLOAT = 2'd2,
        SLP_HOLD  = 2'd3
    } sleep_mode_e;

    // Register field selector codes used on both write and read ports.
    typedef enum logic [1:0] {
        FLD_ARM    = 2'd0,
        FLD_MODE   = 2'd1,
        FLD_STATUS = 2'd2,
        FLD_LOCK   = 2'd3
    } field_e;

    localparam sleep_mode_e MODE_RESET = SLP_FLOAT;

endpackage

// File: rtl/pss_cfg_regs.sv
// Per-pad configuration storage: arm bit, sleep mode and lock bit.
// Also decodes status-clear requests, which are never blocked by the lock.
// Assumes: wr_pad_i addresses an existing pad; writes are single-cycle.
module pss_cfg_regs
    import pss_pkg::*;
#(
    parameter int NumPads = 4,
    parameter int IdxW    = 2
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_en_i,
    input  field_e                    wr_field_i,
    input  logic [IdxW-1:0]           wr_pad_i,
    input  logic [1:0]                wr_data_i,
    output logic [NumPads-1:0]        arm_o,
    output logic [NumPads-1:0][1:0]   mode_o,
    output logic [NumPads-1:0]        lock_o,
    output logic [NumPads-1:0]        clr_req_o
);

    for (genvar p = 0; p < NumPads; p++) begin : g_pad
        logic hit;
        logic arm_q;
        logic lock_q;
        sleep_mode_e mode_q;

        // Select this pad when the write index matches.
        assign hit = wr_en_i && (wr_pad_i == IdxW'(p));

        // Arm and mode registers, guarded by the lock bit.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                arm_q  <= 1'b0;
                mode_q <= MODE_RESET;
            end else if (hit && lock_q) begin
                if (wr_field_i == FLD_ARM) begin
                    arm_q <= wr_data_i[0];
                end
                if (wr_field_i == FLD_MODE) begin
                    mode_q <= sleep_mode_e'(wr_data_i);
                end
            end
        end

        // Lock bit: only a write of 0 changes it; reset restores it.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                lock_q <= 1'b1;
            end else if (hit && (wr_field_i == FLD_LOCK) && !wr_data_i[0]) begin
                lock_q <= 1'b0;
            end
        end

        // Status clear request: a write of 0 to the status field.
        assign clr_req_o[p] = hit && (wr_field_i == FLD_STATUS) && !wr_data_i[0];

        assign arm_o[p]  = arm_q;
        assign lock_o[p] = lock_q;
        assign mode_o[p] = mode_q;
    end

endmodule

// File: rtl/pss_sleep_state.sv
// Per-pad sticky sleep status and hold-mode capture registers.
// Entry sets the status of armed pads and captures the normal drive
// only if the status was clear; entry takes priority over a clear.
// Assumes: sleep_entry_i is synchronous to clk_i.
module pss_sleep_state #(
    parameter int NumPads = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sleep_entry_i,
    input  logic [NumPads-1:0] arm_i,
    input  logic [NumPads-1:0] clr_req_i,
    input  logic [NumPads-1:0] norm_out_i,
    input  logic [NumPads-1:0] norm_oe_i,
    output logic [NumPads-1:0] status_o,
    output logic [NumPads-1:0] hold_out_o,
    output logic [NumPads-1:0] hold_oe_o
);

    for (genvar p = 0; p < NumPads; p++) begin : g_pad
        logic enter;
        logic status_q;
        logic hold_out_q;
        logic hold_oe_q;

        // Entry applies to this pad only if it is armed.
        assign enter = sleep_entry_i && arm_i[p];

        // Sticky status: set on entry, cleared by software otherwise.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                status_q <= 1'b0;
            end else if (enter) begin
                status_q <= 1'b1;
            end else if (clr_req_i[p]) begin
                status_q <= 1'b0;
            end
        end

        // Capture the normal drive on the edge that first sets status.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                hold_out_q <= 1'b0;
                hold_oe_q  <= 1'b0;
            end else if (enter && !status_q) begin
                hold_out_q <= norm_out_i[p];
                hold_oe_q  <= norm_oe_i[p];
            end
        end

        assign status_o[p]   = status_q;
        assign hold_out_o[p] = hold_out_q;
        assign hold_oe_o[p]  = hold_oe_q;
    end

endmodule

// File: rtl/pss_pad_override.sv
// Per-pad output selector: normal drive when awake, sleep behaviour
// otherwise. Purely combinational.
// Assumes: hold values are valid whenever status is set in hold mode.
module pss_pad_override
    import pss_pkg::*;
#(
    parameter int NumPads = 4
) (
    input  logic [NumPads-1:0]      status_i,
    input  logic [NumPads-1:0][1:0] mode_i,
    input  logic [NumPads-1:0]      norm_out_i,
    input  logic [NumPads-1:0]      norm_oe_i,
    input  logic [NumPads-1:0]      hold_out_i,
    input  logic [NumPads-1:0]      hold_oe_i,
    output logic [NumPads-1:0]      pad_out_o,
    output logic [NumPads-1:0]      pad_oe_o
);

    for (genvar p = 0; p < NumPads; p++) begin : g_pad
        // Choose the drive for this pad from status and mode.
        always_comb begin
            if (!status_i[p]) begin
                pad_out_o[p] = norm_out_i[p];
                pad_oe_o[p]  = norm_oe_i[p];
            end else begin
                unique case (sleep_mode_e'(mode_i[p]))
                    SLP_LOW: begin
                        pad_out_o[p] = 1'b0;
                        pad_oe_o[p]  = 1'b1;
                    end
                    SLP_HIGH: begin
                        pad_out_o[p] = 1'b1;
                        pad_oe_o[p]  = 1'b1;
                    end
                    SLP_FLOAT: begin
                        pad_out_o[p] = 1'b0;
                        pad_oe_o[p]  = 1'b0;
                    end
                    default: begin
                        pad_out_o[p] = hold_out_i[p];
                        pad_oe_o[p]  = hold_oe_i[p];
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pad_sleep_ctrl.sv
// Top of the pad deep-sleep controller: configuration registers, sticky
// sleep state, the per-pad override and a combinational readback mux.
// Assumes: synchronous active-low reset held for at least one edge.
module pad_sleep_ctrl
    import pss_pkg::*;
#(
    parameter int NumPads = 4,
    localparam int IdxW   = (NumPads > 1) ? $clog2(NumPads) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sleep_entry_i,
    input  logic [NumPads-1:0] norm_out_i,
    input  logic [NumPads-1:0] norm_oe_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_field_i,
    input  logic [IdxW-1:0]    wr_pad_i,
    input  logic [1:0]         wr_data_i,
    input  logic [1:0]         rd_field_i,
    input  logic [IdxW-1:0]    rd_pad_i,
    output logic [1:0]         rd_data_o,
    output logic [NumPads-1:0] pad_out_o,
    output logic [NumPads-1:0] pad_oe_o,
    output logic [NumPads-1:0] status_o
);

    logic [NumPads-1:0]      arm_q;
    logic [NumPads-1:0][1:0] mode_q;
    logic [NumPads-1:0]      lock_q;
    logic [NumPads-1:0]      clr_req;
    logic [NumPads-1:0]      status_q;
    logic [NumPads-1:0]      hold_out_q;
    logic [NumPads-1:0]      hold_oe_q;

    pss_cfg_regs #(
        .NumPads (NumPads),
        .IdxW    (IdxW)
    ) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_field_i (field_e'(wr_field_i)),
        .wr_pad_i   (wr_pad_i),
        .wr_data_i  (wr_data_i),
        .arm_o      (arm_q),
        .mode_o     (mode_q),
        .lock_o     (lock_q),
        .clr_req_o  (clr_req)
    );

    pss_sleep_state #(
        .NumPads (NumPads)
    ) u_state (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .sleep_entry_i (sleep_entry_i),
        .arm_i         (arm_q),
        .clr_req_i     (clr_req),
        .norm_out_i    (norm_out_i),
        .norm_oe_i     (norm_oe_i),
        .status_o      (status_q),
        .hold_out_o    (hold_out_q),
        .hold_oe_o     (hold_oe_q)
    );

    pss_pad_override #(
        .NumPads (NumPads)
    ) u_ovr (
        .status_i   (status_q),
        .mode_i     (mode_q),
        .norm_out_i (norm_out_i),
        .norm_oe_i  (norm_oe_i),
        .hold_out_i (hold_out_q),
        .hold_oe_i  (hold_oe_q),
        .pad_out_o  (pad_out_o),
        .pad_oe_o   (pad_oe_o)
    );

    // Readback: pick the addressed pad, then the selected field.
    always_comb begin
        rd_data_o = 2'b00;
        for (int p = 0; p < NumPads; p++) begin
            if (rd_pad_i == IdxW'(p)) begin
                unique case (field_e'(rd_field_i))
                    FLD_ARM:    rd_data_o = {1'b0, arm_q[p]};
                    FLD_MODE:   rd_data_o = mode_q[p];
                    FLD_STATUS: rd_data_o = {1'b0, status_q[p]};
                    default:    rd_data_o = {1'b0, lock_q[p]};
                endcase
            end
        end
    end

    assign status_o = status_q;

endmodule

// File: rtl/pss_sleep_chk.sv
// Property checker for the pad deep-sleep controller, bound to the top.
// Assumes: reset is low from time zero until at least one clock edge.
module pss_sleep_chk #(
    parameter int NumPads = 4,
    parameter int IdxW    = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      sleep_entry,
    input logic                      wr_en,
    input logic [1:0]                wr_field,
    input logic [IdxW-1:0]           wr_pad,
    input logic [1:0]                wr_data,
    input logic [NumPads-1:0]        arm,
    input logic [NumPads-1:0][1:0]   mode,
    input logic [NumPads-1:0]        lock,
    input logic [NumPads-1:0]        status,
    input logic [NumPads-1:0]        hold_out,
    input logic [NumPads-1:0]        hold_oe,
    input logic [NumPads-1:0]        norm_out,
    input logic [NumPads-1:0]        norm_oe,
    input logic [NumPads-1:0]        pad_out,
    input logic [NumPads-1:0]        pad_oe
);

    for (genvar p = 0; p < NumPads; p++) begin : g_pad
        logic clr_wr;
        assign clr_wr = wr_en && (wr_field == 2'd2) && (wr_pad == IdxW'(p)) && !wr_data[0];

        // R4
        entry_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sleep_entry && arm[p] |=> status[p]);

        // R5
        status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            status[p] && !clr_wr |=> status[p]);

        // R2
        force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            status[p] && (mode[p] == 2'd0) |-> pad_oe[p] && !pad_out[p]);

        // R2
        force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            status[p] && (mode[p] == 2'd1) |-> pad_oe[p] && pad_out[p]);

        // R3
        release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            status[p] && (mode[p] == 2'd2) |-> !pad_oe[p]);

        // R7
        awake_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !status[p] |-> (pad_out[p] == norm_out[p]) && (pad_oe[p] == norm_oe[p]));

        // R6
        lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !lock[p] |=> !lock[p] && $stable(arm[p]) && $stable(mode[p]));

        // R9
        hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            status[p] |=> $stable(hold_out[p]) && $stable(hold_oe[p]));
    end

endmodule

bind pad_sleep_ctrl pss_sleep_chk #(
    .NumPads (NumPads),
    .IdxW    (IdxW)
) u_pss_chk (
    .clk         (clk_i),
    .rst_n       (rst_ni),
    .sleep_entry (sleep_entry_i),
    .wr_en       (wr_en_i),
    .wr_field    (wr_field_i),
    .wr_pad      (wr_pad_i),
    .wr_data     (wr_data_i),
    .arm         (arm_q),
    .mode        (mode_q),
    .lock        (lock_q),
    .status      (status_q),
    .hold_out    (hold_out_q),
    .hold_oe     (hold_oe_q),
    .norm_out    (norm_out_i),
    .norm_oe     (norm_oe_i),
    .pad_out     (pad_out_o),
    .pad_oe      (pad_oe_o)
);

// File: tb/pad_sleep_ctrl_bench.sv
// Self-checking bench: table-driven sleep-mode walk on pad 0, then
// directed tests for reset, stickiness, lock, recapture and priority.
module pad_sleep_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int W = 2;

    // Vector fields: [5:4] mode, [3] normal out, [2] normal oe,
    // [1] expected out, [0] expected oe.
    localparam logic [5:0] VECS [0:7] = '{
        6'b00_11_01, 6'b00_00_01, 6'b01_00_11, 6'b01_10_11,
        6'b10_11_00, 6'b11_11_11, 6'b11_01_01, 6'b11_10_10
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_entry = 1'b0;
    logic [N-1:0] norm_out = '0;
    logic [N-1:0] norm_oe = '0;
    logic wr_en = 1'b0;
    logic [1:0] wr_field = '0;
    logic [W-1:0] wr_pad = '0;
    logic [1:0] wr_data = '0;
    logic [1:0] rd_field = '0;
    logic [W-1:0] rd_pad = '0;
    logic [1:0] rd_data;
    logic [N-1:0] pad_out, pad_oe, status;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pad_sleep_ctrl #(.NumPads(N)) u_pad_sleep_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .sleep_entry_i(sleep_entry),
        .norm_out_i(norm_out), .norm_oe_i(norm_oe),
        .wr_en_i(wr_en), .wr_field_i(wr_field), .wr_pad_i(wr_pad),
        .wr_data_i(wr_data), .rd_field_i(rd_field), .rd_pad_i(rd_pad),
        .rd_data_o(rd_data), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .status_o(status)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle register write, issued and released on falling edges.
    task automatic wr(logic [1:0] f, logic [W-1:0] p, logic [1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_field = f; wr_pad = p; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] f, logic [W-1:0] p, output logic [1:0] d);
        rd_field = f; rd_pad = p;
        #1;
        d = rd_data;
    endtask

    // Entry pulse over one rising edge; the normal inputs change right after.
    task automatic pulse(logic [N-1:0] next_out, logic [N-1:0] next_oe);
        @(negedge clk);
        sleep_entry = 1'b1;
        @(negedge clk);
        sleep_entry = 1'b0;
        norm_out = next_out; norm_oe = next_oe;
        #1;
    endtask

    initial begin
        logic [1:0] d;
        norm_out = 4'b1010; norm_oe = 4'b0110;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state and passthrough
        chk("R1 status", {4'b0, status}, 8'h00);
        chk("R1 out", {4'b0, pad_out}, 8'h0a);
        chk("R1 oe", {4'b0, pad_oe}, 8'h06);
        for (int p = 0; p < N; p++) begin
            rd(2'd1, W'(p), d); chk("R1 R11 mode", {6'b0, d}, 8'h02);
            rd(2'd0, W'(p), d); chk("R1 R11 arm", {6'b0, d}, 8'h00);
            rd(2'd3, W'(p), d); chk("R1 R11 lock", {6'b0, d}, 8'h01);
        end

        // Table walk on pad 0: R2, R3, R8, R4, R5
        wr(2'd0, 2'd0, 2'd1);
        for (int i = 0; i < 8; i++) begin
            logic [5:0] v;
            v = VECS[i];
            wr(2'd1, 2'd0, v[5:4]);
            @(negedge clk);
            norm_out[0] = v[3]; norm_oe[0] = v[2];
            pulse({norm_out[N-1:1], ~v[3]}, {norm_oe[N-1:1], ~v[2]});
            chk("R4 status set", {7'b0, status[0]}, 8'h01);
            chk("R2 R3 R8 out", {7'b0, pad_out[0]}, {7'b0, v[1]});
            chk("R2 R3 R8 oe", {7'b0, pad_oe[0]}, {7'b0, v[0]});
            wr(2'd2, 2'd0, 2'd0);
            #1;
            chk("R5 cleared", {7'b0, status[0]}, 8'h00);
            chk("R5 normal out", {7'b0, pad_out[0]}, {7'b0, ~v[3]});
            chk("R5 normal oe", {7'b0, pad_oe[0]}, {7'b0, ~v[2]});
        end
        wr(2'd0, 2'd0, 2'd0);

        // R5 write 1 has no effect; R7 unarmed pad 2 stays normal
        wr(2'd1, 2'd1, 2'd0);
        wr(2'd0, 2'd1, 2'd1);
        norm_out = 4'b0110; norm_oe = 4'b0110;
        pulse(4'b0110, 4'b0110);
        wr(2'd2, 2'd1, 2'd1);
        #1;
        chk("R5 write one ignored", {7'b0, status[1]}, 8'h01);
        chk("R2 pad1 low", {6'b0, pad_oe[1], pad_out[1]}, 8'h02);
        chk("R7 pad2 status", {7'b0, status[2]}, 8'h00);
        chk("R7 pad2 out", {7'b0, pad_out[2]}, 8'h01);
        norm_out[2] = 1'b0; norm_oe[2] = 1'b0;
        #1;
        chk("R7 pad2 follows", {6'b0, pad_oe[2], pad_out[2]}, 8'h00);

        // R9 no recapture on second entry (pad 3, hold mode)
        wr(2'd1, 2'd3, 2'd3);
        wr(2'd0, 2'd3, 2'd1);
        @(negedge clk);
        norm_out[3] = 1'b1; norm_oe[3] = 1'b1;
        pulse(norm_out & 4'b0111, norm_oe & 4'b0111);
        chk("R8 pad3 held", {6'b0, pad_oe[3], pad_out[3]}, 8'h03);
        pulse(norm_out, norm_oe);
        chk("R9 pad3 not recaptured", {6'b0, pad_oe[3], pad_out[3]}, 8'h03);

        // R10 clear and entry in the same cycle: entry wins
        @(negedge clk);
        sleep_entry = 1'b1;
        wr_en = 1'b1; wr_field = 2'd2; wr_pad = 2'd3; wr_data = 2'd0;
        @(negedge clk);
        sleep_entry = 1'b0; wr_en = 1'b0;
        #1;
        chk("R10 entry wins", {7'b0, status[3]}, 8'h01);
        chk("R10 R9 still held", {6'b0, pad_oe[3], pad_out[3]}, 8'h03);
        wr(2'd2, 2'd3, 2'd0);
        #1;
        chk("R5 R10 later clear", {7'b0, status[3]}, 8'h00);

        // R6 lock on pad 2
        wr(2'd3, 2'd2, 2'd0);
        rd(2'd3, 2'd2, d); chk("R6 lock cleared", {6'b0, d}, 8'h00);
        wr(2'd1, 2'd2, 2'd0);
        rd(2'd1, 2'd2, d); chk("R6 mode locked", {6'b0, d}, 8'h02);
        wr(2'd0, 2'd2, 2'd1);
        rd(2'd0, 2'd2, d); chk("R6 arm locked", {6'b0, d}, 8'h00);
        wr(2'd3, 2'd2, 2'd1);
        rd(2'd3, 2'd2, d); chk("R6 lock stays", {6'b0, d}, 8'h00);
        wr(2'd1, 2'd0, 2'd3);
        rd(2'd1, 2'd0, d); chk("R6 R11 other pad free", {6'b0, d}, 8'h03);
        pulse(norm_out, norm_oe);
        chk("R6 R7 locked pad unarmed", {7'b0, status[2]}, 8'h00);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule